// File: doc/BRIEF.md
# I2C EEPROM Target Controller

This block acts as a byte-addressed serial EEPROM on a shared two-wire bus. It watches SCL and SDA through synchronizers clocked by the system clock. It finds START and STOP conditions and answers only to its own 7-bit bus address. After a write-direction address byte it takes a 16-bit memory address, sent high byte first. Data bytes that follow are collected in a page buffer. The array itself is an on-chip RAM whose address width is a parameter.

A write reaches the array only when the host ends the transfer with STOP. The block then starts a self-timed write cycle and raises `busy_o`. While that cycle runs it ignores its own address. A host finds out that the write has finished by sending the address again until it gets an ACK, which is known as acknowledge polling. Reads can be current-address, random (address bytes followed by a repeated START) or sequential. A read continues for as long as the host ACKs each byte and stops at the host's NACK.

Top module: `eeprom_i2c_target`

## Requirements
- R1: The target ACKs an address byte only when its upper seven bits are binary 1010 followed by `strap_i[2:0]` (bit 2 first) and no write cycle is running. For any other address byte it leaves SDA released and does nothing until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START at any point begins a new address phase, and a STOP releases SDA.
- R3: After an ACKed address byte whose direction bit is 0, the next two bytes form the memory address, high byte first, and the target ACKs each of them. The pointer takes the low `MEM_AW` bits of that 16-bit value.
- R4: Each data byte of a write goes to the pointer's offset within its 128-byte page. Only the low 7 bits of the pointer then advance, wrapping to offset 0 of the same page, so bytes past the page end overwrite the start of that page.
- R5: A STOP that ends a write with at least one data byte, while `wp_i` is low, starts a write cycle. `busy_o` goes high for `max(TWR_CYCLES, 128)` clock cycles, and the target NACKs its own address during that time. The array is updated only while the cycle runs.
- R6: A repeated START after the two memory-address bytes, followed by a read-direction address byte, returns data starting at the address just sent.
- R7: In a read, each byte comes from the pointer, and the pointer then advances by one across the whole array, wrapping from the top address to 0.
- R8: A read that starts without address bytes (current-address read) begins at the pointer value left by the previous transfer.
- R9: While `wp_i` is high at STOP, the data bytes are still ACKed, but `busy_o` stays low and the array is unchanged.
- R10: Data bytes of a write that ends in a repeated START instead of a STOP are discarded. No write cycle starts and the array is unchanged.
- R11: A host NACK on a read byte ends the read, and the target leaves SDA released until the next START.
- R12: After reset, `sda_oe_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| strap_i | input | 3 | Board straps that set the low three bits of the bus address |
| wp_i | input | 1 | Write protect, high blocks commits to the array |
| sda_oe_o | output | 1 | High pulls the SDA line low |
| busy_o | output | 1 | High while the self-timed write cycle runs |

## Verification
A pointer that is wrong after the address phase shows up in the very first byte read back. A broken page wrap shows up as wrong bytes at the start of the page, or as damage to the neighbouring page, when that page is next read. A write-cycle timer that runs too long or too short changes how many polling attempts get a NACK. An enable that fires when it should not shows up as `busy_o` going high or as changed bytes in the next read. A transmit or ACK state that is off by one bit corrupts every bit that follows, so a read shows the fault within one byte.

// File: rtl/eeprom_i2c_pkg.sv
// Shared types and constants for the I2C EEPROM target.
// Assumes: a 4-bit fixed device identifier ahead of three strap bits.
package eeprom_i2c_pkg;

    localparam logic [3:0] DEV_ID = 4'b1010;

    // Bit-level state of the bus engine
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_st_t;

    // Which byte of a transfer is being received
    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } byte_ph_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and flags
// SCL edges and START/STOP conditions, one cycle each.
// Assumes: SCL high and low phases last several system clocks; STAGES >= 2.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    // Shift both lines through the synchronizer chain; idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[STAGES-2:0], sda_i};
            scl_d  <= scl_sr[STAGES-1];
            sda_d  <= sda_sr[STAGES-1];
        end
    end

    assign scl_s     = scl_sr[STAGES-1];
    assign sda_s     = sda_sr[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/write_cycle_timer.sv
// Times the internal write cycle and steps a commit index over the page
// during its first PAGE_BYTES cycles.
// Assumes: TWR >= 2**PAGE_W, so the commit ends before the cycle does.
module write_cycle_timer #(
    parameter int TWR    = 625000,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              commit_en,
    output logic [PAGE_W-1:0] commit_idx
);

    localparam int             CW    = $clog2(TWR + 1);
    localparam logic [CW-1:0]  TW    = CW'(TWR);
    localparam logic [CW-1:0]  PBYTE = CW'(2 ** PAGE_W);

    logic [CW-1:0] cnt;
    logic [CW-1:0] elapsed;

    // Load on start, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start && cnt == '0) begin
            cnt <= TW;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy       = (cnt != '0);
    assign elapsed    = TW - cnt;
    assign commit_en  = busy && (elapsed < PBYTE);
    assign commit_idx = elapsed[PAGE_W-1:0];

endmodule

// File: rtl/page_buffer.sv
// Holds one page of write data with a per-byte valid flag. A second
// read port feeds the commit engine.
// Assumes: clr and wr_en are never high in the same cycle.
module page_buffer #(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);

    localparam int PBYTES = 2 ** PAGE_W;

    logic [7:0]        mem [PBYTES];
    logic [PBYTES-1:0] vld;

    // Store a received byte in its page slot
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // One valid flag per slot: cleared by a new address, set by a write
    for (genvar g = 0; g < PBYTES; g++) begin : g_vld
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                vld[g] <= 1'b0;
            end else if (wr_en && wr_idx == PAGE_W'(g)) begin
                vld[g] <= 1'b1;
            end
        end
    end

    assign rd_valid = vld[rd_idx];
    assign rd_data  = mem[rd_idx];

endmodule

// File: rtl/eeprom_array.sv
// Byte-wide storage array with one write port and a registered read port.
// Assumes: contents are undefined after power-up.
module eeprom_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 2 ** ADDR_W;

    logic [7:0] mem [DEPTH];

    // Write one byte and read one byte per cycle
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/eeprom_i2c_target.sv
// I2C target that behaves as a serial EEPROM: address match with straps,
// 16-bit memory address, buffered page writes committed after STOP,
// self-timed write cycle with address NACK, and pointer-based reads.
// Assumes: SCL phases last at least four system clocks; 8 <= MEM_AW <= 16.
module eeprom_i2c_target
    import eeprom_i2c_pkg::*;
#(
    parameter int MEM_AW     = 10,
    parameter int PAGE_W     = 7,
    parameter int TWR_CYCLES = 625000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o,
    output logic       busy_o
);

    localparam int TWR_EFF = imax(TWR_CYCLES, 2 ** PAGE_W);
    localparam int BASE_W  = MEM_AW - PAGE_W;

    logic              scl_rise, scl_fall, sda_s, start_det, stop_det;
    bus_st_t           st;
    byte_ph_t          ph;
    logic [3:0]        bitcnt;
    logic [7:0]        sh;
    logic [7:0]        tx_sh;
    logic              rw;
    logic [7:0]        addr_hi;
    logic [MEM_AW-1:0] ptr;
    logic              have_data;
    logic              oe;
    logic [BASE_W-1:0] page_base;
    logic              buf_we, buf_clr;
    logic [PAGE_W-1:0] buf_idx;
    logic [7:0]        buf_dat;
    logic              wc_start, commit_en, slot_vld;
    logic [PAGE_W-1:0] commit_idx;
    logic [7:0]        slot_dat, rd_data;
    logic              arr_we;
    logic [MEM_AW-1:0] arr_waddr;
    logic              dev_hit;

    i2c_line_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .start_det(start_det), .stop_det(stop_det)
    );

    write_cycle_timer #(.TWR(TWR_EFF), .PAGE_W(PAGE_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .start(wc_start), .busy(busy_o),
        .commit_en(commit_en), .commit_idx(commit_idx)
    );

    page_buffer #(.PAGE_W(PAGE_W)) pbuf_i (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_we),
        .wr_idx(buf_idx), .wr_data(buf_dat), .rd_idx(commit_idx),
        .rd_valid(slot_vld), .rd_data(slot_dat)
    );

    eeprom_array #(.ADDR_W(MEM_AW)) array_i (
        .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(slot_dat),
        .raddr(ptr), .rdata(rd_data)
    );

    // A committing STOP needs buffered data and an unprotected array
    assign wc_start  = stop_det && have_data && !wp_i;
    assign arr_we    = commit_en && slot_vld;
    assign arr_waddr = {page_base, commit_idx};
    assign dev_hit   = (sh[7:1] == {DEV_ID, strap_i}) && !busy_o;
    assign sda_oe_o  = oe;

    // Latch the page being committed when a write cycle starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_base <= '0;
        end else if (wc_start) begin
            page_base <= ptr[MEM_AW-1:PAGE_W];
        end
    end

    // Bus engine: bit shifting, ACK timing, pointer and buffer updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ph        <= PH_DEV;
            bitcnt    <= '0;
            sh        <= '0;
            tx_sh     <= '0;
            rw        <= 1'b0;
            addr_hi   <= '0;
            ptr       <= '0;
            have_data <= 1'b0;
            oe        <= 1'b0;
            buf_we    <= 1'b0;
            buf_clr   <= 1'b0;
            buf_idx   <= '0;
            buf_dat   <= '0;
        end else begin
            buf_we  <= 1'b0;
            buf_clr <= 1'b0;
            if (start_det) begin
                st        <= ST_RX;
                ph        <= PH_DEV;
                bitcnt    <= '0;
                oe        <= 1'b0;
                have_data <= 1'b0;
            end else if (stop_det) begin
                st        <= ST_IDLE;
                oe        <= 1'b0;
                have_data <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            sh     <= {sh[6:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            case (ph)
                                PH_DEV: begin
                                    if (dev_hit) begin
                                        rw <= sh[0];
                                        oe <= 1'b1;
                                        st <= ST_RX_ACK;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                PH_AHI: begin
                                    addr_hi <= sh;
                                    oe      <= 1'b1;
                                    st      <= ST_RX_ACK;
                                end
                                PH_ALO: begin
                                    ptr     <= MEM_AW'({addr_hi, sh});
                                    buf_clr <= 1'b1;
                                    oe      <= 1'b1;
                                    st      <= ST_RX_ACK;
                                end
                                default: begin
                                    buf_we    <= 1'b1;
                                    buf_idx   <= ptr[PAGE_W-1:0];
                                    buf_dat   <= sh;
                                    ptr       <= {ptr[MEM_AW-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                                    have_data <= 1'b1;
                                    oe        <= 1'b1;
                                    st        <= ST_RX_ACK;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (ph == PH_DEV && rw) begin
                                tx_sh <= rd_data;
                                oe    <= ~rd_data[7];
                                ptr   <= ptr + 1'b1;
                                st    <= ST_TX;
                            end else begin
                                oe <= 1'b0;
                                st <= ST_RX;
                                if (ph == PH_DEV)      ph <= PH_AHI;
                                else if (ph == PH_AHI) ph <= PH_ALO;
                                else                   ph <= PH_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                oe <= 1'b0;
                                st <= ST_TX_ACK;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                oe     <= ~tx_sh[6];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise && sda_s) begin
                            st <= ST_IDLE;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            tx_sh  <= rd_data;
                            oe     <= ~rd_data[7];
                            ptr    <= ptr + 1'b1;
                            st     <= ST_TX;
                        end
                    end
                    default: begin
                        oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/eeprom_i2c_target_chk.sv
// Property checker for the EEPROM target, attached by bind.
// Assumes: TWR_EFF matches the target's effective write-cycle length.
module eeprom_i2c_target_chk #(
    parameter int TWR_EFF = 128
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic wp,
    input logic arr_we,
    input logic stop_det,
    input logic sda_oe
);

    int busy_cnt;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else busy_cnt <= 0;
    end

    // R5: write cycle lasts exactly the configured length
    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_cnt == TWR_EFF);

    // R5: the array only changes inside a write cycle
    p_commit_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R9: a write cycle never starts from a protected STOP
    p_wp_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp));

    // R2: STOP releases the data line
    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk #(.TWR_EFF(TWR_EFF)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy_o), .wp(wp_i),
    .arr_we(arr_we), .stop_det(stop_det), .sda_oe(sda_oe_o)
);

// File: tb/eeprom_i2c_target_tb_top.sv
// Self-checking bench: full page-write and read sweeps of a 256-byte array.
module eeprom_i2c_target_tb_top;

    localparam int AW  = 8;
    localparam int TWR = 300;
    localparam int Q   = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_h = 1'b1, wp = 1'b0;
    logic [2:0] strap = 3'd5;
    logic sda_oe, busy;
    wire  sda_bus = sda_h & ~sda_oe;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] model [256];
    logic [7:0] wbuf  [256];

    always #4 clk = ~clk;

    eeprom_i2c_target #(.MEM_AW(AW), .PAGE_W(7), .TWR_CYCLES(TWR)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .strap_i(strap), .wp_i(wp), .sda_oe_o(sda_oe), .busy_o(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_h = 1'b1; qw(); scl = 1'b1; qw(); sda_h = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic i2c_stop();
        sda_h = 1'b0; qw(); scl = 1'b1; qw(); sda_h = 1'b1; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0;
        end
        sda_h = 1'b1; qw(); scl = 1'b1; qw(); ack = ~sda_bus; qw(); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_h = 1'b1; qw(); scl = 1'b1; qw(); b[i] = sda_bus; qw(); scl = 1'b0;
        end
        sda_h = ~ack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0;
    endtask

    function automatic logic [6:0] dev_addr();
        return {4'b1010, strap};
    endfunction

    // Start, write-direction address, two memory-address bytes (R3)
    task automatic set_ptr(input logic [15:0] a);
        logic ack;
        i2c_start();
        send_byte({dev_addr(), 1'b0}, ack); chk(ack, "R3 dev ack", ack, 1);
        send_byte(a[15:8], ack);           chk(ack, "R3 hi ack", ack, 1);
        send_byte(a[7:0], ack);            chk(ack, "R3 lo ack", ack, 1);
    endtask

    // Repeated START then read n bytes, compare against model from base
    task automatic read_from(input int base, input int n, input string tag);
        logic ack;
        logic [7:0] b;
        i2c_start();
        send_byte({dev_addr(), 1'b1}, ack); chk(ack, "R6 read dev ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(b === model[(base + i) % 256], tag, b, model[(base + i) % 256]);
        end
    endtask

    // Write n bytes of wbuf from address a and update the page-wrapped model
    task automatic write_seq(input int a, input int n, input bit commit);
        logic ack;
        set_ptr(16'(a));
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk(ack, "R4 data ack", ack, 1);
            if (commit) model[(a & 8'h80) | ((a + i) & 8'h7f)] = wbuf[i];
        end
    endtask

    // Acknowledge polling; returns the number of NACKed attempts
    task automatic poll(output int nacks);
        logic ack;
        nacks = 0;
        for (int k = 0; k < 20; k++) begin
            i2c_start();
            send_byte({dev_addr(), 1'b0}, ack);
            i2c_stop();
            if (ack) break;
            nacks++;
        end
    endtask

    initial begin
        int   nk;
        logic ack;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sda_oe == 1'b0, "R12 sda_oe after reset", sda_oe, 0);
        chk(busy == 1'b0, "R12 busy after reset", busy, 0);

        // R1: sweep address bytes, only 1010+strap gets an ACK
        for (int x = 8'h48; x < 8'h60; x++) begin
            i2c_start();
            send_byte({7'(x), 1'b0}, ack);
            i2c_stop();
            chk(ack == (x == 8'h55), "R1 address sweep", ack, (x == 8'h55));
        end
        strap = 3'd2;
        i2c_start(); send_byte(8'hA4, ack); i2c_stop();
        chk(ack, "R1 new strap ack", ack, 1);
        i2c_start(); send_byte(8'hAA, ack); i2c_stop();
        chk(!ack, "R1 old strap nack", ack, 0);

        // R4/R5: fill both pages, poll after each commit
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 128; i++) wbuf[i] = 8'((p * 128 + i) * 37 + 11);
            write_seq(p * 128, 128, 1'b1);
            i2c_stop();
            chk(busy == 1'b1, "R5 busy after STOP", busy, 1);
            poll(nk);
            chk(nk >= 1 && nk <= 4, "R5 polling nacks", nk, 2);
            chk(busy == 1'b0, "R5 busy ended", busy, 0);
        end

        // R6/R7: random read from 0, full sweep plus wrap at top
        set_ptr(16'h0000);
        read_from(0, 257, "R7 sequential read");
        i2c_stop();
        // R8: current-address read continues at 1
        read_from(1, 1, "R8 current address");
        chk(sda_oe == 1'b0, "R11 released after NACK", sda_oe, 0);
        i2c_stop();

        // R4: write 10 bytes from offset 120 of page 1; wraps to offsets 0,1
        for (int i = 0; i < 10; i++) wbuf[i] = 8'hA0 + 8'(i);
        write_seq(248, 10, 1'b1);
        i2c_stop();
        poll(nk);
        set_ptr(16'h0000);
        read_from(0, 256, "R4 page wrap readback");
        i2c_stop();

        // R3: upper address bits beyond the array are dropped
        set_ptr(16'hFF05);
        read_from(5, 1, "R3 truncated address");
        i2c_stop();

        // R9: protected write is ACKed but never committed
        wp = 1'b1;
        for (int i = 0; i < 3; i++) wbuf[i] = 8'h11 + 8'(i);
        write_seq(5, 3, 1'b0);
        i2c_stop();
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R9 no cycle under protect", busy, 0);
        wp = 1'b0;
        set_ptr(16'h0005);
        read_from(5, 3, "R9 array unchanged");
        i2c_stop();

        // R10: repeated START after data discards it; read starts at ptr 12
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        write_seq(10, 2, 1'b0);
        read_from(12, 1, "R10 read after data");
        i2c_stop();
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R10 no cycle after restart", busy, 0);
        set_ptr(16'h000A);
        read_from(10, 2, "R10 array unchanged");
        i2c_stop();

        // R2: a fresh START after STOP is served normally
        i2c_start(); send_byte(8'hA4, ack); i2c_stop();
        chk(ack, "R2 new transfer after STOP", ack, 1);
        chk(sda_oe == 1'b0, "R2 released after STOP", sda_oe, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule